// File: doc/BRIEF.md
# Count Register and Special-Register Move Unit

This block is a small special-purpose register file that sits beside the integer pipeline. It holds a 64-bit loop count register, a 64-bit return-address (link) register, a 32-bit fixed-point exception register, a 32-bit decrementer and a 64-bit timebase. Move instructions reach it one at a time on a valid/ready request channel. The channel carries the raw 32-bit instruction word and the 64-bit general-register source value. The block decodes the special-register number and applies a write. For a read it returns the register contents on a valid/ready response channel.

Each accepted request produces exactly one response. A request is accepted on a rising clock edge when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response slot is empty or the consumer is taking the current response in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response holds its data and flags stable and no new request is accepted.

A separate plain control input, `ctr_dec`, serves counter-based branches. It decrements the full 64-bit count register. One cycle later it reports whether the low 32 bits of the new value are zero. The count register is stored and read back at full width. Only the branch test narrows it to 32 bits.

Top module: `spr_move_unit`

## Requirements
- R1: A request is a move when instruction bits [31:26] equal 31. Bits [10:1] then select the direction: 467 moves a value into a special register and 339 moves one out. The register number is {instr[15:11], instr[20:16]}, meaning the two 5-bit halves are swapped in the word.
- R2: Register numbers are: count 9, link 8, exception 1, decrementer 22, timebase read 268, timebase-low write 284, timebase-high write 285. A write to the count register (number 9) stores all 64 source bits, and a later read returns all 64 bits unchanged (e.g. 0xFFFFFFFF_80000001).
- R3: A write to the link register stores all 64 bits, and a read returns them.
- R4: The exception register and the decrementer keep only the low 32 bits of a written value. A read returns them zero-extended to 64 bits.
- R5: A write to number 284 replaces the low 32 bits of the timebase and leaves the upper 32 bits unchanged. A write to 285 replaces the upper 32 bits and leaves the lower 32 unchanged. A read of 268 returns all 64 bits.
- R6: When `ctr_dec` is high on a clock edge, the count register becomes its full 64-bit value minus 1 (with wraparound). From the next cycle, `ctr_zero` is high exactly when the low 32 bits of that new value are zero.
- R7: If a count-register write is accepted on the same edge as `ctr_dec`, the write wins, the decrement is dropped, and `ctr_zero` keeps its previous value.
- R8: A read of an unsupported or write-only number, a write to an unsupported or read-only number, or a non-move instruction returns `rsp_illegal`=1 with `rsp_data`=0 and changes no register.
- R9: The response to a move-to request has `rsp_data`=0 and `rsp_illegal`=0. The response to a legal read carries the register value sampled before the accepting edge, so a read on the same edge as a decrement returns the pre-decrement count.
- R10: `req_ready` = !`rsp_valid` || `rsp_ready`. Under back-pressure the response holds stable and nothing new is accepted. Each accepted request yields exactly one response.
- R11: After reset, every register reads zero, `rsp_valid` is 0 and `ctr_zero` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_instr | input | 32 | Raw move instruction word |
| req_src | input | 64 | General-register source value for a write |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 64 | Read result, zero for writes and illegal requests |
| rsp_illegal | output | 1 | Request named an unsupported register or was not a move |
| ctr_dec | input | 1 | Decrement the count register this cycle |
| ctr_zero | output | 1 | Low 32 bits of the last decremented count are zero |

## Verification
Every register change becomes visible at the ports through a later read or through `ctr_zero`. A wrong count width appears on the first read-back of a value with nonzero upper bits, one response after the write. A wrong decrement or a wrong zero-test width appears on `ctr_zero` one cycle after `ctr_dec`. The tests place values so that the full-width and low-32-bit answers differ. A lost or corrupted timebase half is seen on the next read of the whole timebase. A bad response hold shows up in the cycle after `rsp_ready` is dropped.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned SPRN_W  = 10;

  localparam logic [5:0]        OPC_MOVE = 6'd31;
  localparam logic [SPRN_W-1:0] XO_TO    = 10'd467;
  localparam logic [SPRN_W-1:0] XO_FROM  = 10'd339;

  localparam logic [SPRN_W-1:0] NUM_EXC  = 10'd1;
  localparam logic [SPRN_W-1:0] NUM_LNK  = 10'd8;
  localparam logic [SPRN_W-1:0] NUM_CNT  = 10'd9;
  localparam logic [SPRN_W-1:0] NUM_DECR = 10'd22;
  localparam logic [SPRN_W-1:0] NUM_TBRD = 10'd268;
  localparam logic [SPRN_W-1:0] NUM_TBLO = 10'd284;
  localparam logic [SPRN_W-1:0] NUM_TBHI = 10'd285;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_EXC, SEL_LNK, SEL_CNT, SEL_DECR, SEL_TBRD, SEL_TBLO, SEL_TBHI
  } spr_sel_e;

  typedef struct packed {
    logic     is_to;
    logic     is_from;
    spr_sel_e sel;
    logic     legal;
  } spr_op_t;
endpackage

// File: rtl/spr_decode.sv
module spr_decode
  import spr_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output spr_op_t            op
);
  logic [5:0]        primary;
  logic [SPRN_W-1:0] xo;
  logic [SPRN_W-1:0] sprn;
  spr_sel_e          sel;
  logic              to_ok;
  logic              from_ok;

  always_comb begin
    primary = instr[31:26];
    xo      = instr[10:1];
    // halves of the register field arrive swapped
    sprn    = {instr[15:11], instr[20:16]};
  end

  always_comb begin
    unique case (sprn)
      NUM_EXC:  sel = SEL_EXC;
      NUM_LNK:  sel = SEL_LNK;
      NUM_CNT:  sel = SEL_CNT;
      NUM_DECR: sel = SEL_DECR;
      NUM_TBRD: sel = SEL_TBRD;
      NUM_TBLO: sel = SEL_TBLO;
      NUM_TBHI: sel = SEL_TBHI;
      default:  sel = SEL_NONE;
    endcase
  end

  always_comb begin
    to_ok   = (sel != SEL_NONE) && (sel != SEL_TBRD);
    from_ok = (sel != SEL_NONE) && (sel != SEL_TBLO) && (sel != SEL_TBHI);
    op.is_to   = (primary == OPC_MOVE) && (xo == XO_TO);
    op.is_from = (primary == OPC_MOVE) && (xo == XO_FROM);
    op.sel     = sel;
    op.legal   = (op.is_to && to_ok) || (op.is_from && from_ok);
  end
endmodule

// File: rtl/spr_regfile.sv
module spr_regfile
  import spr_pkg::*;
#(
  parameter int unsigned DW = 64,
  parameter int unsigned HW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  spr_sel_e      wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          dec_en,
  output logic [DW-1:0] cnt_q,
  output logic [DW-1:0] lnk_q,
  output logic [HW-1:0] exc_q,
  output logic [HW-1:0] decr_q,
  output logic [DW-1:0] tb_q,
  output logic          cnt_zero
);
  localparam int unsigned UW = DW - HW;

  logic          wr_cnt;
  logic          dec_only;
  logic [DW-1:0] cnt_m1;

  always_comb begin
    wr_cnt   = wr_en && (wr_sel == SEL_CNT);
    dec_only = dec_en && !wr_cnt;
    cnt_m1   = cnt_q - DW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      cnt_zero <= 1'b0;
    end else if (wr_cnt) begin
      cnt_q <= wr_data;
    end else if (dec_en) begin
      cnt_q    <= cnt_m1;
      cnt_zero <= (cnt_m1[HW-1:0] == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lnk_q  <= '0;
      exc_q  <= '0;
      decr_q <= '0;
      tb_q   <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_LNK:  lnk_q  <= wr_data;
        SEL_EXC:  exc_q  <= wr_data[HW-1:0];
        SEL_DECR: decr_q <= wr_data[HW-1:0];
        SEL_TBLO: tb_q[HW-1:0] <= wr_data[HW-1:0];
        SEL_TBHI: tb_q[DW-1:HW] <= wr_data[UW-1:0];
        default: ;
      endcase
    end
  end

  AST_CNT_DEC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    dec_only |=> cnt_q == $past(cnt_q) - DW'(1)); // R6
  AST_ZERO_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_zero) |-> cnt_q[HW-1:0] == '0); // R6
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(wr_data) && $stable(cnt_zero)); // R7
  AST_TB_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_TBLO) |=> tb_q[DW-1:HW] == $past(tb_q[DW-1:HW])); // R5
  AST_TB_LOWER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_TBHI) |=> tb_q[HW-1:0] == $past(tb_q[HW-1:0])); // R5
endmodule

// File: rtl/spr_read_mux.sv
module spr_read_mux
  import spr_pkg::*;
#(
  parameter int unsigned DW = 64,
  parameter int unsigned HW = 32
) (
  input  spr_sel_e      sel,
  input  logic [DW-1:0] cnt_q,
  input  logic [DW-1:0] lnk_q,
  input  logic [HW-1:0] exc_q,
  input  logic [HW-1:0] decr_q,
  input  logic [DW-1:0] tb_q,
  output logic [DW-1:0] rd_data
);
  always_comb begin
    case (sel)
      SEL_CNT:  rd_data = cnt_q;
      SEL_LNK:  rd_data = lnk_q;
      SEL_EXC:  rd_data = DW'(exc_q);
      SEL_DECR: rd_data = DW'(decr_q);
      SEL_TBRD: rd_data = tb_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/spr_move_unit.sv
module spr_move_unit
  import spr_pkg::*;
#(
  parameter int unsigned DW = 64,
  parameter int unsigned HW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [INSTR_W-1:0] req_instr,
  input  logic [DW-1:0]      req_src,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DW-1:0]      rsp_data,
  output logic               rsp_illegal,
  input  logic               ctr_dec,
  output logic               ctr_zero
);
  spr_op_t       op;
  logic          accept;
  logic          wr_en;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] lnk_q;
  logic [HW-1:0] exc_q;
  logic [HW-1:0] decr_q;
  logic [DW-1:0] tb_q;

  spr_decode u_dec (
    .instr (req_instr),
    .op    (op)
  );

  always_comb begin
    req_ready = !rsp_valid || rsp_ready;
    accept    = req_valid && req_ready;
    wr_en     = accept && op.is_to && op.legal;
  end

  spr_regfile #(.DW(DW), .HW(HW)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (op.sel),
    .wr_data  (req_src),
    .dec_en   (ctr_dec),
    .cnt_q    (cnt_q),
    .lnk_q    (lnk_q),
    .exc_q    (exc_q),
    .decr_q   (decr_q),
    .tb_q     (tb_q),
    .cnt_zero (ctr_zero)
  );

  spr_read_mux #(.DW(DW), .HW(HW)) u_mux (
    .sel     (op.sel),
    .cnt_q   (cnt_q),
    .lnk_q   (lnk_q),
    .exc_q   (exc_q),
    .decr_q  (decr_q),
    .tb_q    (tb_q),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      rsp_illegal <= 1'b0;
    end else if (accept) begin
      rsp_valid   <= 1'b1;
      rsp_data    <= (op.is_from && op.legal) ? rd_data : '0;
      rsp_illegal <= !op.legal;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data) && $stable(rsp_illegal)); // R10
  AST_ILLEGAL_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_illegal) |-> rsp_data == '0); // R8
  AST_NO_ACCEPT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R10
endmodule

// File: tb/tb_spr_move_unit.sv
module tb_spr_move_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_instr = '0;
  logic [63:0] req_src = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_data;
  logic        rsp_illegal;
  logic        ctr_dec = 1'b0;
  logic        ctr_zero;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spr_move_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_instr(req_instr), .req_src(req_src), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_illegal(rsp_illegal),
    .ctr_dec(ctr_dec), .ctr_zero(ctr_zero)
  );

  function automatic logic [31:0] mk(input logic [9:0] xo, input logic [9:0] num);
    return {6'd31, 5'd3, num[4:0], num[9:5], xo, 1'b0};
  endfunction
  function automatic logic [31:0] mk_to(input logic [9:0] num);
    return mk(10'd467, num);
  endfunction
  function automatic logic [31:0] mk_from(input logic [9:0] num);
    return mk(10'd339, num);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [63:0] r_data;
  logic        r_ill;

  task automatic op(input logic [31:0] ins, input logic [63:0] src, input logic dec);
    @(negedge clk);
    req_valid = 1'b1; req_instr = ins; req_src = src; ctr_dec = dec;
    @(negedge clk);
    req_valid = 1'b0; ctr_dec = 1'b0;
    r_data = rsp_data; r_ill = rsp_illegal;
    chk("R10 one response", {63'd0, rsp_valid}, 64'd1);
  endtask

  task automatic dec_pulse();
    @(negedge clk); ctr_dec = 1'b1;
    @(negedge clk); ctr_dec = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 rsp_valid", {63'd0, rsp_valid}, 0);
    chk("R11 ctr_zero", {63'd0, ctr_zero}, 0);
    op(mk_from(10'd9), 0, 0);  chk("R11 count", r_data, 0);
    op(mk_from(10'd268), 0, 0); chk("R11 timebase", r_data, 0);
  endtask

  task automatic t_count_roundtrip();
    op(mk_to(10'd9), 64'hFFFFFFFF_80000001, 0);
    chk("R9 write rsp data", r_data, 0); chk("R9 write rsp legal", {63'd0, r_ill}, 0);
    op(mk_from(10'd9), 0, 0); chk("R2 count full width", r_data, 64'hFFFFFFFF_80000001);
    chk("R1 read legal", {63'd0, r_ill}, 0);
  endtask

  task automatic t_link_exc_decr();
    op(mk_to(10'd8), 64'hDEADBEEF_CAFEF00D, 0);
    op(mk_from(10'd8), 0, 0); chk("R3 link", r_data, 64'hDEADBEEF_CAFEF00D);
    op(mk_to(10'd1), 64'h12345678_9ABCDEF0, 0);
    op(mk_from(10'd1), 0, 0); chk("R4 exception low half", r_data, 64'h00000000_9ABCDEF0);
    op(mk_to(10'd22), 64'hFFFFFFFF_00000042, 0);
    op(mk_from(10'd22), 0, 0); chk("R4 decrementer low half", r_data, 64'h42);
  endtask

  task automatic t_timebase();
    op(mk_to(10'd285), 64'h00000000_AABBCCDD, 0);
    op(mk_to(10'd284), 64'hFFFFFFFF_11223344, 0);
    op(mk_from(10'd268), 0, 0); chk("R5 lower write keeps upper", r_data, 64'hAABBCCDD_11223344);
    op(mk_to(10'd285), 64'h55667788, 0);
    op(mk_from(10'd268), 0, 0); chk("R5 upper write keeps lower", r_data, 64'h55667788_11223344);
  endtask

  task automatic t_decrement();
    op(mk_to(10'd9), 64'hFFFFFFFF_00000001, 0);
    dec_pulse(); chk("R6 zero on low half", {63'd0, ctr_zero}, 1);
    op(mk_from(10'd9), 0, 0); chk("R6 full value after dec", r_data, 64'hFFFFFFFF_00000000);
    dec_pulse(); chk("R6 nonzero after borrow", {63'd0, ctr_zero}, 0);
    op(mk_from(10'd9), 0, 0); chk("R6 borrow into upper", r_data, 64'hFFFFFFFE_FFFFFFFF);
    op(mk_to(10'd9), 64'h00000001_00000001, 0);
    dec_pulse(); chk("R6 upper set low zero", {63'd0, ctr_zero}, 1);
    op(mk_to(10'd9), 64'h0, 0);
    dec_pulse(); chk("R6 wrap from zero", {63'd0, ctr_zero}, 0);
    op(mk_from(10'd9), 0, 0); chk("R6 wrap value", r_data, 64'hFFFFFFFF_FFFFFFFF);
  endtask

  task automatic t_collision();
    op(mk_to(10'd9), 64'h1, 0);
    dec_pulse(); chk("R7 setup zero", {63'd0, ctr_zero}, 1);
    op(mk_to(10'd9), 64'h5, 1);
    chk("R7 zero flag kept", {63'd0, ctr_zero}, 1);
    op(mk_from(10'd9), 0, 1); chk("R7 write wins / R9 pre-dec read", r_data, 64'h5);
    op(mk_from(10'd9), 0, 0); chk("R9 decrement after read", r_data, 64'h4);
  endtask

  task automatic t_illegal();
    op(mk_from(10'd284), 0, 0);
    chk("R8 write-only read flag", {63'd0, r_ill}, 1); chk("R8 data zero", r_data, 0);
    op(mk_to(10'd268), 64'h99, 0);
    chk("R8 read-only write flag", {63'd0, r_ill}, 1);
    op(mk_to(10'd100), 64'h77, 0);
    chk("R8 unknown number flag", {63'd0, r_ill}, 1);
    op(mk_from(10'd268), 0, 0); chk("R8 timebase untouched", r_data, 64'h55667788_11223344);
    op({6'd30, 5'd3, 5'd9, 5'd0, 10'd467, 1'b0}, 64'hAB, 0);
    chk("R1 wrong primary flag", {63'd0, r_ill}, 1);
    op(mk(10'd466, 10'd9), 64'hAB, 0);
    chk("R1 wrong extended flag", {63'd0, r_ill}, 1);
    op(mk_from(10'd9), 0, 0); chk("R8 count untouched", r_data, 64'h4);
    op({6'd31, 5'd3, 5'd9, 5'd0, 10'd339, 1'b0}, 0, 0);
    chk("R1 swapped halves give count", r_data, 64'h4);
    op({6'd31, 5'd3, 5'd0, 5'd9, 10'd339, 1'b0}, 0, 0);
    chk("R1 unswapped is 288 illegal", {63'd0, r_ill}, 1);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_instr = mk_from(10'd8); req_src = 0;
    @(negedge clk);
    req_instr = mk_to(10'd8); req_src = 64'h1;
    chk("R10 ready low when held", {63'd0, req_ready}, 0);
    @(negedge clk);
    chk("R10 held data", rsp_data, 64'hDEADBEEF_CAFEF00D);
    chk("R10 still valid", {63'd0, rsp_valid}, 1);
    rsp_ready = 1'b1; req_valid = 1'b0;
    @(negedge clk);
    chk("R10 drained", {63'd0, rsp_valid}, 0);
    op(mk_from(10'd8), 0, 0); chk("R10 stalled write not taken", r_data, 64'hDEADBEEF_CAFEF00D);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count_roundtrip();
    t_link_exc_decr();
    t_timebase();
    t_decrement();
    t_collision();
    t_illegal();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule